// File: doc/BRIEF.md
# Transceiver Control-Port SPI Register Slave

This block is the serial control port of a radio transceiver. An SPI master frames each transaction with an active-low select. The first byte of every frame is a command. Its upper nibble chooses the operation and its lower nibble gives a starting register index. The block holds a file of ten configuration bytes. It serves burst writes and burst reads of that file, plus a compact two-byte channel command that updates the channel number, the PA power and the band select in one step.

While the command byte is being shifted in, the slave returns a status byte on MISO that is built from two status inputs. Every configuration field is exported as its own parallel output, so the radio logic never has to decode register bytes. The SPI pins are resampled into the system clock domain. All protocol logic runs on that single clock and uses edge strobes taken from the resampled serial clock.

Top module: `cfgspi_slave`

## Requirements
- R1: Serial clock edges seen while `spi_csn` is high have no effect. Raising `spi_csn` in the middle of a byte abandons that frame, and the next frame starts decoding a new command byte. While `spi_csn` is high, `spi_miso` is 0.
- R2: A command with upper nibble 4'h0 is a burst write. The lower nibble is the first register index, and each following byte goes to the next consecutive index.
- R3: A command with upper nibble 4'h1 is a burst read. The bytes that follow the command return the contents of consecutive registers, starting at the index in the lower nibble.
- R4: A command with upper nibble 4'h8 is a channel command. Command bit 0 becomes channel bit 8 and the next byte becomes channel bits 7:0. Command bits 3:2 set the PA power and command bit 1 sets the band select. Register 1 bits 5:4 are kept.
- R5: During the command byte, MISO returns a status byte. Bit 7 is `addr_match`, bit 5 is `data_ready` and every other bit is 0.
- R6: The field layout is as follows, and each field appears on its output:
  - Register 0 holds channel bits 7:0.
  - Register 1 holds auto-retransmit (bit 5), reduced RX power (bit 4), PA power (bits 3:2), band select (bit 1) and channel bit 8 (bit 0).
  - Register 2 holds the TX address width (bits 6:4) and the RX address width (bits 2:0).
  - Registers 3 and 4 hold the RX and TX payload widths in bits 5:0.
  - Registers 5 to 8 hold the RX address, with register 5 as the least significant byte.
  - Register 9 holds CRC 16-bit mode (bit 7), CRC enable (bit 6), the crystal code (bits 5:3), clock-out enable (bit 2) and clock-out select (bits 1:0).
- R7: Unimplemented bits are discarded on write and read back as 0. These are register 1 bits 7:6, register 2 bits 7 and 3, and registers 3 and 4 bits 7:6.
- R8: A write or read byte whose register index is above 9 pulses `cfg_err` high for exactly one cycle, leaves every register unchanged, and reads back as 8'h00.
- R9: The crystal code only holds the values 0 to 4. A register 9 write that carries code 5, 6 or 7 keeps the old code and still updates the other bits.
- R10: A data byte takes effect only once its eighth bit has been received. A channel command changes nothing unless its second byte completes.
- R11: A synchronous active-high `rst` clears all registers and drives `spi_miso` to 0.
- R12: SPI mode 0 is used, MSB first. MOSI is sampled on the rising serial clock and MISO changes after the falling serial clock. The first status bit is presented once select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_csn | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| addr_match | input | 1 | Status input, returned in status bit 7 |
| data_ready | input | 1 | Status input, returned in status bit 5 |
| cfg_err | output | 1 | One-cycle pulse on an out-of-range register access |
| chan | output | 9 | Channel number |
| auto_retx | output | 1 | Auto-retransmit enable |
| rx_lowpwr | output | 1 | Reduced-power receive |
| pa_pwr | output | 2 | PA power code |
| hi_band | output | 1 | High band select |
| tx_aw | output | 3 | TX address width |
| rx_aw | output | 3 | RX address width |
| rx_pw | output | 6 | RX payload width |
| tx_pw | output | 6 | TX payload width |
| rx_addr | output | 32 | RX address, register 5 in bits 7:0 |
| crc_16 | output | 1 | CRC length: 1 = 16-bit, 0 = 8-bit |
| crc_en | output | 1 | CRC enable |
| xtal_sel | output | 3 | Crystal frequency code (0 to 4) |
| clkout_en | output | 1 | Clock-out enable |
| clkout_sel | output | 2 | Clock-out frequency select |

## Verification
The checks assume the following about the inputs:
- Each serial clock half-period and each select transition last well beyond the resampling delay, so one serial edge never merges into another.
- Select stays high for several system cycles between frames.
- `addr_match` and `data_ready` are synchronous to `clk` and stay steady during a command byte.
- Reset is held for at least two cycles.

The stimulus meets all of these. It holds every serial level for six system cycles, keeps select high for over a dozen cycles between frames, changes the status inputs only while select is high, and asserts reset for several cycles.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;

    localparam int NUM_REGS  = 10;
    localparam int IDX_BITS  = 4;
    localparam int XTAL_MAX  = 4;

    localparam logic [3:0] OP_WRITE = 4'h0;
    localparam logic [3:0] OP_READ  = 4'h1;
    localparam logic [3:0] OP_CHAN  = 4'h8;

    typedef struct packed {
        logic [3:0] op;
        logic [3:0] start;
    } cmd_t;

    typedef struct packed {
        logic [8:0]  chan;
        logic        auto_retx;
        logic        rx_lowpwr;
        logic [1:0]  pa_pwr;
        logic        hi_band;
        logic [2:0]  tx_aw;
        logic [2:0]  rx_aw;
        logic [5:0]  rx_pw;
        logic [5:0]  tx_pw;
        logic [31:0] rx_addr;
        logic        crc_16;
        logic        crc_en;
        logic [2:0]  xtal_sel;
        logic        clkout_en;
        logic [1:0]  clkout_sel;
    } cfg_fields_t;

    // Bits that exist in each register; all others are held at zero.
    function automatic logic [7:0] reg_mask(input logic [IDX_BITS-1:0] idx);
        case (idx)
            4'd1, 4'd3, 4'd4: reg_mask = 8'h3F;
            4'd2:             reg_mask = 8'h77;
            default:          reg_mask = 8'hFF;
        endcase
    endfunction

    // New register value after a write, including the crystal-code range guard.
    function automatic logic [7:0] merge_write(input logic [IDX_BITS-1:0] idx,
                                               input logic [7:0] old_val,
                                               input logic [7:0] new_val);
        logic [7:0] res;
        res = new_val & reg_mask(idx);
        if (idx == 4'd9 && int'(new_val[5:3]) > XTAL_MAX)
            res[5:3] = old_val[5:3];
        return res;
    endfunction

    function automatic logic [7:0] status_byte(input logic am, input logic dr);
        return {am, 1'b0, dr, 5'b0};
    endfunction

endpackage

// File: rtl/cfgspi_sync_edge.sv
module cfgspi_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_in,
    input  logic csn_in,
    input  logic mosi_in,
    output logic sel,
    output logic frame_start,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sck_chain, csn_chain, mosi_chain;
    logic sck_d, sel_d;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_chain[g]  <= 1'b0;
                    csn_chain[g]  <= 1'b1;
                    mosi_chain[g] <= 1'b0;
                end else if (g == 0) begin
                    sck_chain[g]  <= sck_in;
                    csn_chain[g]  <= csn_in;
                    mosi_chain[g] <= mosi_in;
                end else begin
                    sck_chain[g]  <= sck_chain[(g > 0) ? g-1 : 0];
                    csn_chain[g]  <= csn_chain[(g > 0) ? g-1 : 0];
                    mosi_chain[g] <= mosi_chain[(g > 0) ? g-1 : 0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            sel_d <= 1'b0;
        end else begin
            sck_d <= sck_chain[LAST];
            sel_d <= ~csn_chain[LAST];
        end
    end

    assign sel         = ~csn_chain[LAST];
    assign frame_start = sel & ~sel_d;
    assign sck_rise    = sck_chain[LAST] & ~sck_d;
    assign sck_fall    = ~sck_chain[LAST] & sck_d;
    assign mosi_s      = mosi_chain[LAST];
endmodule

// File: rtl/cfgspi_engine.sv
module cfgspi_engine
    import cfgspi_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel,
    input  logic                frame_start,
    input  logic                sck_rise,
    input  logic                sck_fall,
    input  logic                mosi_s,
    input  logic [7:0]          status,
    input  logic [7:0]          rd_data,
    output logic [IDX_BITS-1:0] rd_addr,
    output logic                wr_en,
    output logic [IDX_BITS-1:0] wr_addr,
    output logic [7:0]          wr_data,
    output logic                chan_en,
    output logic [3:0]          chan_cmd,
    output logic [7:0]          chan_lo,
    output logic                err,
    output logic                miso
);
    localparam int ADDR_W = IDX_W + 1;

    logic [2:0]       bit_cnt;
    logic [IDX_W-1:0] byte_idx;
    logic [6:0]       shreg;
    cmd_t             cmd_q;
    logic             miso_q, err_q;

    logic             byte_done, data_byte, addr_ok;
    logic [7:0]       rx_byte, tx_byte;
    logic [ADDR_W-1:0] cur_addr;

    assign rx_byte   = {shreg, mosi_s};
    assign byte_done = sel & sck_rise & (bit_cnt == 3'd7);
    assign data_byte = (byte_idx != '0);
    assign cur_addr  = ADDR_W'(cmd_q.start) + ADDR_W'(byte_idx) - ADDR_W'(1);
    assign addr_ok   = (cur_addr < ADDR_W'(NUM_REGS));
    assign rd_addr   = cur_addr[IDX_BITS-1:0];

    always_comb begin
        if (!data_byte)
            tx_byte = status;
        else if (cmd_q.op == OP_READ && addr_ok)
            tx_byte = rd_data;
        else
            tx_byte = 8'h00;
    end

    assign wr_en    = byte_done & data_byte & (cmd_q.op == OP_WRITE) & addr_ok;
    assign wr_addr  = cur_addr[IDX_BITS-1:0];
    assign wr_data  = rx_byte;
    assign chan_en  = byte_done & (byte_idx == IDX_W'(1)) & (cmd_q.op == OP_CHAN);
    assign chan_cmd = cmd_q.start;
    assign chan_lo  = rx_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            byte_idx <= '0;
            shreg    <= '0;
            cmd_q    <= '0;
            miso_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= byte_done & data_byte & !addr_ok &
                     (cmd_q.op == OP_WRITE || cmd_q.op == OP_READ);
            if (!sel) begin
                bit_cnt  <= '0;
                byte_idx <= '0;
                miso_q   <= 1'b0;
            end else begin
                if (frame_start)
                    miso_q <= status[7];
                if (sck_rise) begin
                    shreg   <= rx_byte[6:0];
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        if (!data_byte)
                            cmd_q <= rx_byte;
                        if (byte_idx != '1)
                            byte_idx <= byte_idx + IDX_W'(1);
                    end
                end
                if (sck_fall)
                    miso_q <= tx_byte[~bit_cnt];
            end
        end
    end

    assign miso = miso_q;
    assign err  = err_q;
endmodule

// File: rtl/cfgspi_regfile.sv
module cfgspi_regfile
    import cfgspi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                chan_en,
    input  logic [3:0]          chan_cmd,
    input  logic [7:0]          chan_lo,
    input  logic [IDX_BITS-1:0] rd_addr,
    output logic [7:0]          rd_data,
    output cfg_fields_t         fields
);
    logic [NUM_REGS-1:0][7:0] regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (chan_en) begin
            regs_q[0] <= chan_lo;
            regs_q[1] <= {regs_q[1][7:4], chan_cmd};
        end else if (wr_en) begin
            regs_q[wr_addr] <= merge_write(wr_addr, regs_q[wr_addr], wr_data);
        end
    end

    assign rd_data = (int'(rd_addr) < NUM_REGS) ? regs_q[rd_addr] : 8'h00;

    always_comb begin
        fields.chan       = {regs_q[1][0], regs_q[0]};
        fields.auto_retx  = regs_q[1][5];
        fields.rx_lowpwr  = regs_q[1][4];
        fields.pa_pwr     = regs_q[1][3:2];
        fields.hi_band    = regs_q[1][1];
        fields.tx_aw      = regs_q[2][6:4];
        fields.rx_aw      = regs_q[2][2:0];
        fields.rx_pw      = regs_q[3][5:0];
        fields.tx_pw      = regs_q[4][5:0];
        fields.rx_addr    = {regs_q[8], regs_q[7], regs_q[6], regs_q[5]};
        fields.crc_16     = regs_q[9][7];
        fields.crc_en     = regs_q[9][6];
        fields.xtal_sel   = regs_q[9][5:3];
        fields.clkout_en  = regs_q[9][2];
        fields.clkout_sel = regs_q[9][1:0];
    end
endmodule

// File: rtl/cfgspi_slave.sv
module cfgspi_slave
    import cfgspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        spi_sck,
    input  logic        spi_csn,
    input  logic        spi_mosi,
    output logic        spi_miso,
    input  logic        addr_match,
    input  logic        data_ready,
    output logic        cfg_err,
    output logic [8:0]  chan,
    output logic        auto_retx,
    output logic        rx_lowpwr,
    output logic [1:0]  pa_pwr,
    output logic        hi_band,
    output logic [2:0]  tx_aw,
    output logic [2:0]  rx_aw,
    output logic [5:0]  rx_pw,
    output logic [5:0]  tx_pw,
    output logic [31:0] rx_addr,
    output logic        crc_16,
    output logic        crc_en,
    output logic [2:0]  xtal_sel,
    output logic        clkout_en,
    output logic [1:0]  clkout_sel
);
    logic sel, frame_start, sck_rise, sck_fall, mosi_s;
    logic wr_en, chan_en;
    logic [IDX_BITS-1:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data, chan_lo;
    logic [3:0] chan_cmd;
    cfg_fields_t fields;

    cfgspi_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sck_in(spi_sck), .csn_in(spi_csn), .mosi_in(spi_mosi),
        .sel(sel), .frame_start(frame_start),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
    );

    cfgspi_engine #(.IDX_W(IDX_W)) u_engine (
        .clk(clk), .rst(rst),
        .sel(sel), .frame_start(frame_start),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
        .status(status_byte(addr_match, data_ready)),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .chan_en(chan_en), .chan_cmd(chan_cmd), .chan_lo(chan_lo),
        .err(cfg_err), .miso(spi_miso)
    );

    cfgspi_regfile u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .chan_en(chan_en), .chan_cmd(chan_cmd), .chan_lo(chan_lo),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .fields(fields)
    );

    assign chan       = fields.chan;
    assign auto_retx  = fields.auto_retx;
    assign rx_lowpwr  = fields.rx_lowpwr;
    assign pa_pwr     = fields.pa_pwr;
    assign hi_band    = fields.hi_band;
    assign tx_aw      = fields.tx_aw;
    assign rx_aw      = fields.rx_aw;
    assign rx_pw      = fields.rx_pw;
    assign tx_pw      = fields.tx_pw;
    assign rx_addr    = fields.rx_addr;
    assign crc_16     = fields.crc_16;
    assign crc_en     = fields.crc_en;
    assign xtal_sel   = fields.xtal_sel;
    assign clkout_en  = fields.clkout_en;
    assign clkout_sel = fields.clkout_sel;
endmodule

// File: rtl/cfgspi_slave_chk.sv
module cfgspi_slave_chk (
    input logic        clk,
    input logic        rst,
    input logic        spi_csn,
    input logic        spi_miso,
    input logic        cfg_err,
    input logic [8:0]  chan,
    input logic [31:0] rx_addr,
    input logic [2:0]  xtal_sel
);
    AST_ERR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> !cfg_err);  // R8

    AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)) |-> !spi_miso);  // R1

    AST_CFG_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
        (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3))
            |-> ($stable(chan) && $stable(rx_addr) && $stable(xtal_sel)));  // R1

    AST_XTAL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        xtal_sel <= 3'd4);  // R9

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (chan == 9'd0 && rx_addr == 32'd0 && !spi_miso));  // R11
endmodule

bind cfgspi_slave cfgspi_slave_chk u_chk (
    .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_miso(spi_miso),
    .cfg_err(cfg_err), .chan(chan), .rx_addr(rx_addr), .xtal_sel(xtal_sel)
);

// File: tb/cfgspi_slave_bench.sv
module cfgspi_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int WATCHDOG   = 150000;

    // {index[3:0], write byte, expected read-back}
    localparam logic [19:0] VT [10] = '{
        20'h0A5A5, 20'h1FF3F, 20'h2FF77, 20'h3FF3F, 20'h4C707,
        20'h51212, 20'h63434, 20'h75656, 20'h87878, 20'h9E2E2
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
    logic addr_match = 1'b0, data_ready = 1'b0;
    logic spi_miso, cfg_err, auto_retx, rx_lowpwr, hi_band;
    logic crc_16, crc_en, clkout_en;
    logic [8:0]  chan;
    logic [1:0]  pa_pwr, clkout_sel;
    logic [2:0]  tx_aw, rx_aw, xtal_sel;
    logic [5:0]  rx_pw, tx_pw;
    logic [31:0] rx_addr;

    int n_checks = 0, n_fail = 0, err_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgspi_slave u_cfgspi_slave (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .addr_match(addr_match), .data_ready(data_ready), .cfg_err(cfg_err),
        .chan(chan), .auto_retx(auto_retx), .rx_lowpwr(rx_lowpwr),
        .pa_pwr(pa_pwr), .hi_band(hi_band), .tx_aw(tx_aw), .rx_aw(rx_aw),
        .rx_pw(rx_pw), .tx_pw(tx_pw), .rx_addr(rx_addr), .crc_16(crc_16),
        .crc_en(crc_en), .xtal_sel(xtal_sel), .clkout_en(clkout_en),
        .clkout_sel(clkout_sel)
    );

    always @(posedge clk) if (!rst && cfg_err) err_cnt <= err_cnt + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = tx[i];
            tick(HALF);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            tick(HALF);
            spi_sck = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic frame_open;
        spi_csn = 1'b0;
        tick(HALF);
    endtask

    task automatic frame_close;
        tick(HALF);
        spi_csn = 1'b1;
        tick(2 * HALF + 2);
    endtask

    task automatic wr1(input logic [3:0] idx, input logic [7:0] d);
        logic [7:0] r;
        frame_open;
        spi_byte({4'h0, idx}, r);
        spi_byte(d, r);
        frame_close;
    endtask

    task automatic rd1(input logic [3:0] idx, output logic [7:0] stat, output logic [7:0] d);
        frame_open;
        spi_byte({4'h1, idx}, stat);
        spi_byte(8'h00, d);
        frame_close;
    endtask

    initial begin
        logic [7:0] st, d;
        int e0;
        tick(5);
        // R11: reset state
        check("R11 miso", {31'd0, spi_miso}, 32'd0);
        check("R11 chan", {23'd0, chan}, 32'd0);
        check("R11 rx_addr", rx_addr, 32'd0);
        rst = 1'b0;
        tick(4);

        // R2 R3 R7: single write then read-back of every register
        for (int k = 0; k < 10; k++) begin
            wr1(VT[k][19:16], VT[k][15:8]);
            rd1(VT[k][19:16], st, d);
            check("R2/R3/R7 readback", {24'd0, d}, {24'd0, VT[k][7:0]});
        end
        check("R8 no error on valid indices", err_cnt, 0);

        // R6: field outputs
        check("R6 chan", {23'd0, chan}, 32'h1A5);
        check("R6 reg1 fields", {27'd0, auto_retx, rx_lowpwr, pa_pwr, hi_band}, 32'h1F);
        check("R6 widths", {8'd0, tx_aw, rx_aw, rx_pw, tx_pw}, {8'd0, 3'd7, 3'd7, 6'h3F, 6'h07});
        check("R6 rx_addr", rx_addr, 32'h78563412);
        check("R6 reg9 fields", {24'd0, crc_16, crc_en, xtal_sel, clkout_en, clkout_sel},
              {24'd0, 8'hE2});

        // R2: burst write from index 5
        frame_open;
        spi_byte(8'h05, st);
        spi_byte(8'hDE, st); spi_byte(8'hAD, st); spi_byte(8'hBE, st); spi_byte(8'hEF, st);
        frame_close;
        check("R2 burst write", rx_addr, 32'hEFBEADDE);

        // R3 R5 R12: burst read with status
        addr_match = 1'b1; data_ready = 1'b0;
        frame_open;
        spi_byte(8'h15, st);
        check("R5 status am", {24'd0, st}, 32'h80);
        spi_byte(8'h00, d); check("R3 burst byte0", {24'd0, d}, 32'hDE);
        spi_byte(8'h00, d); check("R3 burst byte1", {24'd0, d}, 32'hAD);
        spi_byte(8'h00, d); check("R12 burst byte2", {24'd0, d}, 32'hBE);
        spi_byte(8'h00, d); check("R3 burst byte3", {24'd0, d}, 32'hEF);
        frame_close;
        addr_match = 1'b1; data_ready = 1'b1;
        rd1(4'd0, st, d);
        check("R5 status both", {24'd0, st}, 32'hA0);
        addr_match = 1'b0; data_ready = 1'b1;
        rd1(4'd0, st, d);
        check("R5 status dr", {24'd0, st}, 32'h20);
        data_ready = 1'b0;

        // R4: channel command
        frame_open;
        spi_byte(8'h8B, st);
        spi_byte(8'h3C, st);
        frame_close;
        check("R4 chan", {23'd0, chan}, 32'h13C);
        check("R4 pa/band", {29'd0, pa_pwr, hi_band}, {29'd0, 2'b10, 1'b1});
        rd1(4'd1, st, d);
        check("R4 reg1 keeps 5:4", {24'd0, d}, 32'h3B);

        // R10: incomplete channel command and partial data byte
        frame_open;
        spi_byte(8'h80, st);
        frame_close;
        check("R10 chan cmd alone", {23'd0, chan}, 32'h13C);
        frame_open;
        spi_byte(8'h00, st);
        spi_bits(8'hFF, 5, st);
        frame_close;
        rd1(4'd0, st, d);
        check("R10 partial byte", {24'd0, d}, 32'h3C);

        // R8: out-of-range accesses
        e0 = err_cnt;
        wr1(4'hA, 8'h55);
        check("R8 write err pulse", err_cnt - e0, 1);
        check("R8 regs unchanged", rx_addr, 32'hEFBEADDE);
        // R9: burst from 9 with out-of-range crystal code; second byte hits index 10
        frame_open;
        spi_byte(8'h09, st);
        spi_byte(8'h39, st);
        spi_byte(8'h11, st);
        frame_close;
        check("R8 burst overrun err", err_cnt - e0, 2);
        check("R9 xtal kept", {29'd0, xtal_sel}, 32'd4);
        rd1(4'd9, st, d);
        check("R9 reg9 merge", {24'd0, d}, 32'h21);
        rd1(4'hB, st, d);
        check("R8 read invalid", {24'd0, d}, 32'h00);
        check("R8 read err pulse", err_cnt - e0, 3);

        // R1: bus activity with select high is ignored
        e0 = err_cnt;
        spi_bits(8'h00, 8, st);
        spi_bits(8'h5A, 8, st);
        tick(4);
        check("R1 miso idle", {31'd0, spi_miso}, 32'd0);
        check("R1 ignored chan", {23'd0, chan}, 32'h13C);
        check("R1 ignored err", err_cnt - e0, 0);
        // R1: aborted frame, next frame decodes a fresh command
        frame_open;
        spi_bits(8'h00, 4, st);
        frame_close;
        rd1(4'd0, st, d);
        check("R1 restart after abort", {24'd0, d}, 32'h3C);

        // R11: reset clears state
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(2);
        check("R11 chan cleared", {23'd0, chan}, 32'd0);
        check("R11 rx_addr cleared", rx_addr, 32'd0);
        check("R11 xtal cleared", {29'd0, xtal_sel}, 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule